// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the effective address for a synchronous memory that serves bursts of four words. On a load cycle it captures a full external address as the start of a new burst. On each advance cycle it steps to the next beat. Only the two low address bits change during a burst. The upper bits stay at the value captured on the load.

The step order within the four-word block can follow either of two sequences. In linear order the low bits count up and wrap within the block. In interleaved order the low bits are the start value XOR the beat index. The order select is applied combinationally to the stored start and beat index, so a change takes effect on the current beat without reloading. A clock enable freezes all state whenever it is low.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is zero. Reset is asynchronous.
- R2: On a rising clock edge with `en_i`=1 and `advance_i`=0, `addr_i` is loaded. `addr_o` equals it from that edge on, in either order. This is beat 0.
- R3: With `order_i`=0 (linear), each edge with `en_i`=1 and `advance_i`=1 moves to beat n+1. The low two bits of `addr_o` equal (start low bits + n) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R4: With `order_i`=1 (interleaved), the low two bits of `addr_o` at beat n equal start low bits XOR n. For example, start 1 gives 1, 0, 3, 2.
- R5: During advance cycles, bits [17:2] of `addr_o` keep the value loaded, whatever is on `addr_i`.
- R6: An advance after beat 3 returns to beat 0, so `addr_o` equals the start address again. It does not leave the four-word block.
- R7: With `en_i`=0, a clock edge changes no state. `addr_o` holds, whatever `advance_i` and `addr_i` are.
- R8: A change of `order_i` during a burst immediately remaps the current beat index. No clock edge is needed.
- R9: A load during a burst in progress restarts at beat 0 with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable, active high |
| advance_i | input | 1 | 0 = load `addr_i`, 1 = advance beat |
| order_i | input | 1 | 0 = linear, 1 = interleaved |
| addr_i | input | 18 | External start address |
| addr_o | output | 18 | Current effective address |

## Verification
The embedded assertions cover several rules on every clock cycle:
- a load produces the loaded address on the next cycle;
- an advance never disturbs the upper address bits;
- the beat index steps by one, modulo four;
- a disabled clock freezes both the stored start and the beat index.

The actual low-bit sequences can only be shown by the bench's scenarios. These cover linear and interleaved order from every start value, the wrap back to the start after four beats, an order switch in mid-burst, and a reload that interrupts a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (en_i) begin
      if (load_i)    beat_q <= '0;
      else           beat_q <= beat_q + 1'b1;  // wraps at burst length
    end
  end

  assign beat_o = beat_q;

  AST_BEAT_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_i |=> beat_q == '0);  // R9
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));  // R6
  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(beat_q));  // R7
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             base_q <= '0;
    else if (en_i && load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

  AST_BASE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_i |=> base_q == $past(addr_i));  // R2
  AST_BASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && load_i) |=> $stable(base_q));  // R5
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_w;
  logic [BEAT_W-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              advance_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load_w;
  logic [ADDR_W-1:0] base_w;
  logic [BEAT_W-1:0] beat_w;
  logic [BEAT_W-1:0] low_w;
  burst_order_e      order_w;

  assign load_w  = !advance_i;
  assign order_w = burst_order_e'(order_i);

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_w),
    .addr_i(addr_i), .base_o(base_w)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_w),
    .beat_o(beat_w)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i(base_w[BEAT_W-1:0]), .beat_i(beat_w), .order_i(order_w),
    .low_o  (low_w)
  );

  assign addr_o = {base_w[ADDR_W-1:BEAT_W], low_w};

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !advance_i |=> addr_o == $past(addr_i));  // R2
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));  // R5
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);  // R1
  initial assert (HI_W > 0);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, adv = 1'b0, ord = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .advance_i(adv),
    .order_i(ord), .addr_i(addr), .addr_o(addr_o)
  );

  typedef struct packed {
    logic          en;
    logic          adv;
    logic          ord;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 18'h2A5C1, 18'h2A5C1, 4'd2},  // R2
    '{1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h2A5C2, 4'd3},  // R3, R5 junk addr
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h2A5C3, 4'd3},
    '{1'b1, 1'b1, 1'b0, 18'h15555, 18'h2A5C0, 4'd3},
    '{1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h2A5C1, 4'd6},  // R6 wrap
    '{1'b0, 1'b0, 1'b0, 18'h11111, 18'h2A5C1, 4'd7},  // R7
    '{1'b0, 1'b1, 1'b0, 18'h22222, 18'h2A5C1, 4'd7},
    '{1'b1, 1'b0, 1'b1, 18'h1F3E2, 18'h1F3E2, 4'd2},
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h1F3E3, 4'd4},  // R4
    '{1'b1, 1'b1, 1'b1, 18'h3FFFF, 18'h1F3E0, 4'd4},
    '{1'b1, 1'b1, 1'b1, 18'h2AAAA, 18'h1F3E1, 4'd4},
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h1F3E2, 4'd6},
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h1F3E3, 4'd4},
    '{1'b1, 1'b0, 1'b1, 18'h30005, 18'h30005, 4'd9},  // R9
    '{1'b1, 1'b1, 1'b1, 18'h00000, 18'h30004, 4'd4},
    '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h30007, 4'd8}   // R8
  };

  task automatic check(input logic [AW-1:0] exp, input int req, input string what);
    checks++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, addr_o, exp);
    end
  endtask

  task automatic step(input logic e, input logic a, input logic o, input logic [AW-1:0] d);
    @(negedge clk);
    en = e; adv = a; ord = o; addr = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1;
    check('0, 1, "R1 in reset");
    #20 rst_n = 1'b1;
    @(posedge clk); #2;
    check('0, 1, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].en, VEC[i].adv, VEC[i].ord, VEC[i].addr);
      check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R3 R4 R5 R6: every start value and both orders, with wrap
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] st;
        st = {16'hB6D3, 2'(s)};
        step(1'b1, 1'b0, o[0], st);
        check(st, 2, "sweep load");
        for (int n = 1; n <= 4; n++) begin
          logic [1:0] lo;
          lo = (o == 0) ? 2'(s + n) : (2'(s) ^ 2'(n));
          step(1'b1, 1'b1, o[0], ~st);
          check({st[AW-1:2], lo}, (n == 4) ? 6 : (o == 0 ? 3 : 4), "sweep beat");
        end
      end
    end

    // R8: order change remaps current beat without a clock edge
    step(1'b1, 1'b0, 1'b0, 18'h04001);
    step(1'b1, 1'b1, 1'b0, 18'h0);
    check(18'h04002, 3, "linear beat 1");
    @(negedge clk); en = 1'b0; ord = 1'b1; #1;
    check(18'h04000, 8, "switched to interleaved");
    ord = 1'b0; #1;
    check(18'h04002, 8, "switched back to linear");

    // R1: asynchronous reset mid-burst
    #1 rst_n = 1'b0; #1;
    check('0, 1, "async reset");
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule